// File: doc/BRIEF.md
# Amplifier Control Register Bank with Fault-Mute Latch

This block holds the byte-wide configuration registers of a digital audio amplifier controller and owns the mute that a fault raises. Software reaches it through a simple synchronous port: an 8-bit address, 8-bit write data with a write strobe, and a read strobe that loads a registered read-data output. The stored fields leave the block as plain outputs:
- a dither amount;
- a 16-bit saturation clamp assembled from two bytes;
- an enable for predictive gain;
- four 4-bit loop-delay fields, one per output channel.

A fault input forces the fault-mute output high on the next clock. A mode bit selects how the mute is released. In auto mode the mute drops one clock after the fault goes away. In manual mode the mute stays latched until the fault is gone and software then produces a fresh 0-to-1 step on a clear bit. The predictive-gain enable is protected: a write can change it only while the hard-mute status input is high.

Top module: `amp_ctrl_regs`

## Requirements
- R1: After reset the outputs are as follows:
  - dither_o = 00h
  - sat_clamp_o = E7FFh
  - pgain_en_o = 0
  - ch_dly_o = 0000h
  - fault_mute_o = 0
  - address 3Ah reads 04h (auto-release bit 2 = 1, clear bit 1 = 0).
- R2: Address 39h is a full 8-bit read/write dither register driving dither_o.
- R3: Address 3Bh holds the clamp low byte and 3Ch the high byte. sat_clamp_o = {3Ch, 3Bh}.
- R4: The loop-delay fields are mapped as follows, and ch_dly_o carries channel n in bits [4n-1:4n-4]:
  - address 71h: channel 1 in bits [3:0], channel 2 in bits [7:4];
  - address 72h: channel 3 in bits [3:0], channel 4 in bits [7:4].
- R5: Address 3Ah stores the auto-release bit in bit 2 and the clear bit in bit 1. All its other bits read 0.
- R6: While fault_i is high at a clock edge, fault_mute_o is 1 after that edge, whatever the mode.
- R7: With bit 2 of 3Ah = 1, a set mute clears on the first edge where fault_i is low.
- R8: With bit 2 of 3Ah = 0, a set mute clears only on an edge where fault_i is low and the clear bit is 1 while it was 0 one clock earlier. A 0-to-1 step made while fault_i is high does not release the mute. Because a write sets the bit on the write edge, the mute clears on the edge after that write edge.
- R9: Address 3Dh bit 7 is the predictive-gain enable, and bits 6:0 read 0. A write to 3Dh updates the enable only if hard_mute_i is high on the write edge. Otherwise the enable keeps its value.
- R10: Every address other than 39h, 3Ah, 3Bh, 3Ch, 3Dh, 71h and 72h reads 00h, and writes to these addresses change no register.
- R11: rd_data_o is loaded on each edge where rd_en_i is high, is valid after that edge, and holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| fault_i | input | 1 | Fault indication, active high |
| hard_mute_i | input | 1 | Hard-mute status, active high |
| dither_o | output | 8 | Dither amount |
| sat_clamp_o | output | 16 | Saturation clamp word |
| pgain_en_o | output | 1 | Predictive-gain enable |
| ch_dly_o | output | 16 | Four 4-bit loop-delay fields, channel 1 in the low nibble |
| fault_mute_o | output | 1 | Fault-driven mute |

## Verification
The hardest situation to reach is the manual-release corner. There, the clear bit rises while the fault is still present, and that stale step must not release the mute once the fault goes away. The stimulus writes the clear bit high during the fault and drops the fault. It then holds the mute for many cycles and confirms it stays set. Only after that does it write the bit low and then high again, and it checks the exact clock on which the mute falls. Two full sweeps over all 256 addresses compare every readback against an arithmetic shadow model. The second sweep carries a pattern that tries to set the guarded enable while hard-mute is low.

// File: rtl/amp_ctrl_pkg.sv
package amp_ctrl_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_DITHER   = 8'h39;
  localparam logic [ADDR_W-1:0] A_FLT_CTL  = 8'h3A;
  localparam logic [ADDR_W-1:0] A_CLAMP_LO = 8'h3B;
  localparam logic [ADDR_W-1:0] A_CLAMP_HI = 8'h3C;
  localparam logic [ADDR_W-1:0] A_PGAIN    = 8'h3D;
  localparam logic [ADDR_W-1:0] A_DLY_BASE = 8'h71;

  localparam int unsigned FLT_AUTO_BIT  = 2;
  localparam int unsigned FLT_CLEAR_BIT = 1;
  localparam int unsigned PGAIN_BIT     = 7;

  // address of the register holding channel ch's delay nibble
  function automatic logic [ADDR_W-1:0] dly_addr(input int unsigned ch,
                                                  input int unsigned per_reg);
    return ADDR_W'(int'(A_DLY_BASE) + int'(ch / per_reg));
  endfunction
endpackage

// File: rtl/amp_fault_mute.sv
module amp_fault_mute (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic auto_rel_i,
  input  logic clear_i,
  output logic fault_mute_o
);
  logic clear_prev_q;
  logic mute_q;
  logic clear_rise;

  assign clear_rise = clear_i & ~clear_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clear_prev_q <= 1'b0;
      mute_q       <= 1'b0;
    end else begin
      clear_prev_q <= clear_i;
      if (fault_i)                                mute_q <= 1'b1;
      else if (mute_q && (auto_rel_i || clear_rise)) mute_q <= 1'b0;
    end
  end

  assign fault_mute_o = mute_q;

  a_r6_fault_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> mute_q);
  a_r7_auto_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_q && auto_rel_i && !fault_i) |=> !mute_q);
  a_r8_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_q && !auto_rel_i && !clear_rise) |=> mute_q);
  a_r8_release_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_q) |-> !$past(fault_i));
endmodule

// File: rtl/amp_reg_file.sv
module amp_reg_file
  import amp_ctrl_pkg::*;
#(
  parameter int unsigned         NUM_CH     = 4,
  parameter int unsigned         DLY_W      = 4,
  parameter logic [DATA_W-1:0]   DITHER_RST = 8'h00,
  parameter logic [2*DATA_W-1:0] CLAMP_RST  = 16'hE7FF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    pgain_allow_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [DATA_W-1:0]       dither_o,
  output logic [2*DATA_W-1:0]     sat_clamp_o,
  output logic                    pgain_en_o,
  output logic [NUM_CH*DLY_W-1:0] ch_dly_o,
  output logic                    auto_rel_o,
  output logic                    clear_o
);
  localparam int unsigned PER_REG = DATA_W / DLY_W;

  logic [DATA_W-1:0] dither_q, clamp_lo_q, clamp_hi_q, rd_q, rd_mux;
  logic              auto_q, clear_q, pgain_q;
  logic [DLY_W-1:0]  dly_q [NUM_CH];
  logic              hit;

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return wr_en_i && (addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dither_q   <= DITHER_RST;
      clamp_lo_q <= CLAMP_RST[DATA_W-1:0];
      clamp_hi_q <= CLAMP_RST[2*DATA_W-1:DATA_W];
      auto_q     <= 1'b1;
      clear_q    <= 1'b0;
      pgain_q    <= 1'b0;
    end else begin
      if (wr_at(A_DITHER))   dither_q   <= wr_data_i;
      if (wr_at(A_CLAMP_LO)) clamp_lo_q <= wr_data_i;
      if (wr_at(A_CLAMP_HI)) clamp_hi_q <= wr_data_i;
      if (wr_at(A_FLT_CTL)) begin
        auto_q  <= wr_data_i[FLT_AUTO_BIT];
        clear_q <= wr_data_i[FLT_CLEAR_BIT];
      end
      if (wr_at(A_PGAIN) && pgain_allow_i) pgain_q <= wr_data_i[PGAIN_BIT];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dly
    localparam logic [ADDR_W-1:0] CH_ADDR = dly_addr(ch, PER_REG);
    localparam int unsigned       LANE    = ch % PER_REG;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             dly_q[ch] <= '0;
      else if (wr_at(CH_ADDR)) dly_q[ch] <= wr_data_i[LANE*DLY_W +: DLY_W];
    end
    assign ch_dly_o[ch*DLY_W +: DLY_W] = dly_q[ch];
  end

  always_comb begin
    rd_mux = '0;
    hit    = 1'b1;
    unique case (addr_i)
      A_DITHER:   rd_mux = dither_q;
      A_CLAMP_LO: rd_mux = clamp_lo_q;
      A_CLAMP_HI: rd_mux = clamp_hi_q;
      A_FLT_CTL: begin
        rd_mux[FLT_AUTO_BIT]  = auto_q;
        rd_mux[FLT_CLEAR_BIT] = clear_q;
      end
      A_PGAIN:    rd_mux[PGAIN_BIT] = pgain_q;
      default:    hit = 1'b0;
    endcase
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      if (addr_i == dly_addr(ch, PER_REG)) begin
        rd_mux[(ch % PER_REG)*DLY_W +: DLY_W] = dly_q[ch];
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o   = rd_q;
  assign dither_o    = dither_q;
  assign sat_clamp_o = {clamp_hi_q, clamp_lo_q};
  assign pgain_en_o  = pgain_q;
  assign auto_rel_o  = auto_q;
  assign clear_o     = clear_q;

  a_r9_pgain_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pgain_q) |-> $past(pgain_allow_i));
  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rd_q == '0));
  a_r11_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_q));
  a_r5_flt_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_FLT_CTL) |=> (rd_q[7:3] == '0 && rd_q[0] == 1'b0));
endmodule

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs
  import amp_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DLY_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic [DATA_W-1:0]       rd_data_o,
  input  logic                    fault_i,
  input  logic                    hard_mute_i,
  output logic [DATA_W-1:0]       dither_o,
  output logic [2*DATA_W-1:0]     sat_clamp_o,
  output logic                    pgain_en_o,
  output logic [NUM_CH*DLY_W-1:0] ch_dly_o,
  output logic                    fault_mute_o
);
  logic auto_rel, clear_bit;

  amp_reg_file #(.NUM_CH(NUM_CH), .DLY_W(DLY_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wr_data_i,
    .pgain_allow_i(hard_mute_i),
    .rd_data_o, .dither_o, .sat_clamp_o, .pgain_en_o, .ch_dly_o,
    .auto_rel_o(auto_rel), .clear_o(clear_bit)
  );

  amp_fault_mute u_mute (
    .clk_i, .rst_ni, .fault_i,
    .auto_rel_i(auto_rel), .clear_i(clear_bit),
    .fault_mute_o
  );
endmodule

// File: tb/amp_ctrl_regs_tb.sv
module amp_ctrl_regs_tb;
  logic        clk = 0, rst_ni = 0;
  logic        wr_en = 0, rd_en = 0, fault = 0, hmute = 0;
  logic [7:0]  addr = 0, wdata = 0, rdata, dith;
  logic [15:0] clamp, dly;
  logic        pgain, mute;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  amp_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .fault_i(fault), .hard_mute_i(hmute),
    .dither_o(dith), .sat_clamp_o(clamp), .pgain_en_o(pgain), .ch_dly_o(dly),
    .fault_mute_o(mute)
  );

  // shadow model
  logic [7:0] s_dith = 8'h00, s_clo = 8'hFF, s_chi = 8'hE7, s_d71 = 0, s_d72 = 0;
  logic       s_auto = 1, s_clr = 0, s_pg = 0;

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    case (a)
      8'h39: return s_dith;
      8'h3A: return {5'b0, s_auto, s_clr, 1'b0};
      8'h3B: return s_clo;
      8'h3C: return s_chi;
      8'h3D: return {s_pg, 7'b0};
      8'h71: return s_d71;
      8'h72: return s_d72;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    case (a)
      8'h39: s_dith = d;
      8'h3A: begin s_auto = d[2]; s_clr = d[1]; end
      8'h3B: s_clo = d;
      8'h3C: s_chi = d;
      8'h3D: if (hmute) s_pg = d[7];
      8'h71: s_d71 = d;
      8'h72: s_d72 = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dither", dith, 16'h00);
    chk("R1 clamp", clamp, 16'hE7FF);
    chk("R1 pgain", pgain, 0);
    chk("R1 delays", dly, 16'h0000);
    chk("R1 mute", mute, 0);
    rd(8'h3A, v); chk("R1 fault ctl", v, 16'h04);

    // R2 R3 R4 R5 R9 R10: two full sweeps, write all then read all
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 256; a++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'h5A : 8'hA5;
        if (a != 8'h3A) wr(8'(a), 8'(a) ^ pat); // fault ctl handled below
      end
      wr(8'h3A, (p == 0) ? 8'hF9 : 8'h06);
      for (int a = 0; a < 256; a++) begin
        rd(8'(a), v);
        chk("R10 R2 R3 R4 R5 R9 readback", v, model_rd(8'(a)));
      end
      chk("R2 dither_o", dith, s_dith);
      chk("R3 sat_clamp_o", clamp, {s_chi, s_clo});
      chk("R4 ch_dly_o", dly, {s_d72, s_d71});
      chk("R9 pgain blocked", pgain, 0);
    end

    // R11 read data holds while rd_en low
    rd(8'h39, v);
    wr(8'h39, 8'h3C);
    @(negedge clk);
    chk("R11 hold", rdata, v);
    rd(8'h39, v); chk("R11 R2 new value", v, 16'h3C);

    // R9 guarded enable
    for (int h = 0; h < 2; h++)
      for (int b = 0; b < 2; b++) begin
        hmute = h[0];
        wr(8'h3D, b[0] ? 8'hFF : 8'h7F);
        chk("R9 pgain", pgain, s_pg);
        rd(8'h3D, v); chk("R9 pgain read", v, {s_pg, 7'b0});
      end
    hmute = 0;

    // R6 R7 auto release
    wr(8'h3A, 8'h04);
    @(negedge clk); fault = 1;
    @(negedge clk); chk("R6 set auto", mute, 1);
    fault = 0;
    chk("R7 not before edge", mute, 1);
    @(negedge clk); chk("R7 auto clear", mute, 0);

    // R6 R8 manual release, stale rise during fault
    wr(8'h3A, 8'h00);
    @(negedge clk); fault = 1;
    @(negedge clk); chk("R6 set manual", mute, 1);
    wr(8'h3A, 8'h02);
    repeat (3) @(negedge clk);
    fault = 0;
    repeat (20) @(negedge clk);
    chk("R8 stale rise ignored", mute, 1);
    wr(8'h3A, 8'h00);
    repeat (5) @(negedge clk);
    chk("R8 held after clear low", mute, 1);
    wr(8'h3A, 8'h02);
    chk("R8 not yet on write edge", mute, 1);
    @(negedge clk); chk("R8 manual clear", mute, 0);

    // R6 fault during manual mode with bit already high, then R7 via mode flip
    @(negedge clk); fault = 1;
    @(negedge clk); fault = 0;
    chk("R6 set again", mute, 1);
    repeat (4) @(negedge clk);
    chk("R8 level high does not clear", mute, 1);
    wr(8'h3A, 8'h06);
    @(negedge clk); chk("R7 auto after mode flip", mute, 0);

    finish_run();
  end
endmodule